// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This block holds two independent 32-bit up-counters behind a small auxiliary register port. Each timer has a count register, a limit register and a control register. Software loads a start value into the count register. The timer then advances once per enabled cycle until the count equals the limit. On the next enabled cycle the count returns to zero and, if interrupts are enabled, a pending flag is latched. While the flag is set, the timer's own interrupt line stays high.

The control register holds two bits. The interrupt-enable bit sits at bit 0. The halt-gating bit sits at bit 1; when it is set, the timer advances only on cycles in which the processor halt input is low. Any write to a timer's control register clears that timer's pending flag. Software therefore acknowledges an interrupt by rewriting the control register, and the same write chooses the next enable and gating settings.

A typical setup uses timer 0 as an event source with a programmed limit and interrupts enabled. Timer 1 runs as a free-running cycle counter with its limit at all ones and interrupts disabled. Reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `dual_tick_timer`

## Requirements
- R1: Timer 0 decodes count at address 0x021, control at 0x022 and limit at 0x023. Timer 1 decodes count at 0x100, control at 0x101 and limit at 0x102. Count and limit read back all 32 written bits. Control reads back bit 0 (interrupt enable) and bit 1 (halt gating), and every other bit reads as zero.
- R2: Any other address reads as zero, and a write to it changes no register.
- R3: Reset clears every count, limit and control register and both pending flags, so both interrupt outputs are low.
- R4: On each enabled cycle with no count write, the count increases by one. If the count equals the limit on that cycle, the count becomes zero instead.
- R5: If interrupt enable is set when the count equals the limit on an enabled cycle, the timer's interrupt output goes high after that edge. It stays high until the control register is written.
- R6: A limit match while interrupt enable is clear latches nothing. Setting the enable bit afterwards does not raise the interrupt.
- R7: Any write to a timer's control register clears its pending flag, even when a limit match occurs on the same edge. Writing only the halt-gating bit drops the interrupt and keeps further interrupts from being raised.
- R8: With halt gating set, the count holds its value while the halt input is high. With halt gating clear, the count advances on every cycle whatever the halt input.
- R9: A write to the count register takes priority over the increment on the same edge, and that edge is not treated as a limit match.
- R10: With the limit at 0xFFFFFFFF and interrupts disabled, a timer runs freely and wraps from 0xFFFFFFFF to 0 without raising an interrupt.
- R11: The two timers run independently. One timer's configuration and interrupt have no effect on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuHalted | input | 1 | High while the processor is halted |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | 12 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| timerIrq | output | 2 | Interrupt outputs, bit n belongs to timer n |

## Verification
Register reads are combinational, so the bench reads at the same falling edge at which a write task returns. By then the write has taken effect at the rising edge just before. The count shows one increment per rising edge. A bench that waits N falling edges therefore expects exactly N steps, with the wrap to zero on the step that follows the cycle where the count equals the limit. The interrupt output is registered through the pending flag, so it is checked at the falling edge right after the matching rising edge. The acknowledge is checked at the falling edge right after the control write.

// File: rtl/dtt_pkg.sv
`timescale 1ns/1ps
package dtt_pkg;
  localparam int NumTimers = 2;
  localparam int AddrW     = 12;
  localparam int TIdxW     = (NumTimers > 1) ? $clog2(NumTimers) : 1;
  localparam int IeBit     = 0;
  localparam int NhBit     = 1;
  localparam int OffCount  = 0;
  localparam int OffCtrl   = 1;
  localparam int OffLimit  = 2;

  typedef enum logic [1:0] {SEL_NONE, SEL_COUNT, SEL_CTRL, SEL_LIMIT} regSel_e;

  typedef struct packed {
    logic wrCount;
    logic wrCtrl;
    logic wrLimit;
  } tmrStrobe_t;

  function automatic logic [AddrW-1:0] regAddrOf(int idx, int off);
    logic [AddrW-1:0] base;
    base = (idx == 0) ? AddrW'(12'h021) : AddrW'(12'h100);
    return base + AddrW'(off);
  endfunction
endpackage

// File: rtl/dtt_ctrl.sv
`timescale 1ns/1ps
module dtt_ctrl
  import dtt_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             regWr,
  input  logic [AddrW-1:0]                 regAddr,
  output tmrStrobe_t [NumTimers-1:0]       strobes,
  output regSel_e                          rdSel,
  output logic [TIdxW-1:0]                 rdIdx
);
  for (genvar g = 0; g < NumTimers; g++) begin : g_dec
    assign strobes[g].wrCount = regWr && (regAddr == regAddrOf(g, OffCount));
    assign strobes[g].wrCtrl  = regWr && (regAddr == regAddrOf(g, OffCtrl));
    assign strobes[g].wrLimit = regWr && (regAddr == regAddrOf(g, OffLimit));
  end

  always_comb begin
    rdSel = SEL_NONE;
    rdIdx = '0;
    for (int i = 0; i < NumTimers; i++) begin
      if (regAddr == regAddrOf(i, OffCount)) begin
        rdSel = SEL_COUNT;
        rdIdx = TIdxW'(i);
      end else if (regAddr == regAddrOf(i, OffCtrl)) begin
        rdSel = SEL_CTRL;
        rdIdx = TIdxW'(i);
      end else if (regAddr == regAddrOf(i, OffLimit)) begin
        rdSel = SEL_LIMIT;
        rdIdx = TIdxW'(i);
      end
    end
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));
  // R2
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!regWr) |-> (strobes == '0));
endmodule

// File: rtl/dtt_slice.sv
`timescale 1ns/1ps
module dtt_slice
  import dtt_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpuHalted,
  input  tmrStrobe_t       strobe,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] count,
  output logic [DataW-1:0] limit,
  output logic             ie,
  output logic             nh,
  output logic             irq
);
  logic pending;
  logic tick;
  logic hit;

  assign tick = !(nh && cpuHalted);
  assign hit  = tick && !strobe.wrCount && (count == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (strobe.wrCount) begin
      count <= wrData;
    end else if (tick) begin
      count <= hit ? '0 : count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit <= '0;
    end else if (strobe.wrLimit) begin
      limit <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie <= 1'b0;
      nh <= 1'b0;
    end else if (strobe.wrCtrl) begin
      ie <= wrData[IeBit];
      nh <= wrData[NhBit];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (strobe.wrCtrl) begin
      pending <= 1'b0;
    end else if (hit && ie) begin
      pending <= 1'b1;
    end
  end

  assign irq = pending && ie;

  // R9
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrCount |=> (count == $past(wrData)));
  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nh && cpuHalted && !strobe.wrCount) |=> $stable(count));
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(nh && cpuHalted) && !strobe.wrCount && (count != limit))
      |=> (count == $past(count) + 1'b1));
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrCtrl |=> !irq);
  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !strobe.wrCtrl) |=> irq);
endmodule

// File: rtl/dtt_datapath.sv
`timescale 1ns/1ps
module dtt_datapath
  import dtt_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpuHalted,
  input  tmrStrobe_t [NumTimers-1:0] strobes,
  input  regSel_e                    rdSel,
  input  logic [TIdxW-1:0]           rdIdx,
  input  logic [DataW-1:0]           wrData,
  output logic [DataW-1:0]           rdData,
  output logic [NumTimers-1:0]       irqVec
);
  logic [DataW-1:0] cntArr [NumTimers];
  logic [DataW-1:0] limArr [NumTimers];
  logic             ieArr  [NumTimers];
  logic             nhArr  [NumTimers];

  for (genvar g = 0; g < NumTimers; g++) begin : g_tmr
    dtt_slice #(.DataW(DataW)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpuHalted (cpuHalted),
      .strobe    (strobes[g]),
      .wrData    (wrData),
      .count     (cntArr[g]),
      .limit     (limArr[g]),
      .ie        (ieArr[g]),
      .nh        (nhArr[g]),
      .irq       (irqVec[g])
    );
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_COUNT: rdData = cntArr[rdIdx];
      SEL_LIMIT: rdData = limArr[rdIdx];
      SEL_CTRL: begin
        rdData[IeBit] = ieArr[rdIdx];
        rdData[NhBit] = nhArr[rdIdx];
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_tick_timer.sv
`timescale 1ns/1ps
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int DataW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpuHalted,
  input  logic                 regWr,
  input  logic [AddrW-1:0]     regAddr,
  input  logic [DataW-1:0]     regWrData,
  output logic [DataW-1:0]     regRdData,
  output logic [NumTimers-1:0] timerIrq
);
  tmrStrobe_t [NumTimers-1:0] strobes;
  regSel_e                    rdSel;
  logic [TIdxW-1:0]           rdIdx;

  dtt_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .regWr   (regWr),
    .regAddr (regAddr),
    .strobes (strobes),
    .rdSel   (rdSel),
    .rdIdx   (rdIdx)
  );

  dtt_datapath #(.DataW(DataW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpuHalted (cpuHalted),
    .strobes   (strobes),
    .rdSel     (rdSel),
    .rdIdx     (rdIdx),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .irqVec    (timerIrq)
  );
endmodule

// File: tb/sim_dual_tick_timer.sv
`timescale 1ns/1ps
module sim_dual_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpuHalted = 1'b0;
  logic        regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [1:0]  timerIrq;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  dual_tick_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpuHalted (cpuHalted),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .timerIrq  (timerIrq)
  );

  // {address, write data, expected readback}
  localparam logic [75:0] VECS [8] = '{
    {12'h023, 32'h12345678, 32'h12345678},
    {12'h102, 32'hCAFEF00D, 32'hCAFEF00D},
    {12'h022, 32'hFFFFFFFC, 32'h00000000},
    {12'h101, 32'h00000007, 32'h00000003},
    {12'h021, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {12'h100, 32'h5A5A5A5A, 32'h5A5A5A5A},
    {12'h050, 32'hFFFFFFFF, 32'h00000000},
    {12'h123, 32'h00000001, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    regWr = 1'b1;
    regAddr = a;
    regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #0.2;
    d = regRdData;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    waitClk(3);
    // R3 reset state, read while reset is held
    rd(12'h021, v); chk("R3 t0 count", v, 0);
    rd(12'h022, v); chk("R3 t0 ctrl", v, 0);
    rd(12'h023, v); chk("R3 t0 limit", v, 0);
    rd(12'h100, v); chk("R3 t1 count", v, 0);
    rd(12'h101, v); chk("R3 t1 ctrl", v, 0);
    rd(12'h102, v); chk("R3 t1 limit", v, 0);
    chk("R3 irq", {30'd0, timerIrq}, 0);
    rst_n = 1'b1;
    waitClk(1);

    // R1 and R2 register vectors
    for (int i = 0; i < 8; i++) begin
      wr(VECS[i][75:64], VECS[i][63:32]);
      rd(VECS[i][75:64], v);
      chk((i < 6) ? "R1 readback" : "R2 unmapped", v, VECS[i][31:0]);
    end
    @(negedge clk);

    // R4 R5 limit match with interrupt enabled on timer 0
    wr(12'h101, 0);
    wr(12'h023, 5);
    wr(12'h022, 1);
    wr(12'h021, 0);
    rd(12'h021, v); chk("R9 count load", v, 0);
    waitClk(5);
    rd(12'h021, v); chk("R4 count at limit", v, 5);
    chk("R5 irq before match", {31'd0, timerIrq[0]}, 0);
    waitClk(1);
    rd(12'h021, v); chk("R4 reload to zero", v, 0);
    chk("R5 irq after match", {31'd0, timerIrq[0]}, 1);
    waitClk(2);
    chk("R5 irq held", {31'd0, timerIrq[0]}, 1);

    // R7 acknowledge by control write
    wr(12'h022, 1);
    chk("R7 ack clears irq", {31'd0, timerIrq[0]}, 0);
    rd(12'h021, v); chk("R4 counting on", v, 3);
    waitClk(3);
    chk("R5 refire", {31'd0, timerIrq[0]}, 1);
    wr(12'h022, 2);
    chk("R7 nh-only ack", {31'd0, timerIrq[0]}, 0);
    rd(12'h022, v); chk("R1 ctrl nh", v, 2);
    waitClk(6);
    chk("R7 no irq with ie clear", {31'd0, timerIrq[0]}, 0);
    rd(12'h021, v); chk("R4 wrapped count", v, 1);
    waitClk(4);
    wr(12'h022, 1);
    chk("R7 ack wins over match", {31'd0, timerIrq[0]}, 0);
    rd(12'h021, v); chk("R4 reload on ack edge", v, 0);
    waitClk(6);
    chk("R5 fires after ack edge", {31'd0, timerIrq[0]}, 1);

    // R6 match without interrupt enable
    wr(12'h023, 3);
    wr(12'h022, 0);
    wr(12'h021, 0);
    waitClk(4);
    rd(12'h021, v); chk("R6 wrap without ie", v, 0);
    chk("R6 no irq", {31'd0, timerIrq[0]}, 0);
    wr(12'h022, 1);
    waitClk(1);
    chk("R6 late enable no irq", {31'd0, timerIrq[0]}, 0);

    // R8 halt gating
    cpuHalted = 1'b1;
    wr(12'h023, 1000);
    wr(12'h022, 2);
    wr(12'h021, 10);
    waitClk(5);
    rd(12'h021, v); chk("R8 frozen while halted", v, 10);
    cpuHalted = 1'b0;
    waitClk(3);
    rd(12'h021, v); chk("R8 runs when not halted", v, 13);
    cpuHalted = 1'b1;
    wr(12'h022, 0);
    rd(12'h021, v); chk("R8 old gating on write edge", v, 13);
    waitClk(4);
    rd(12'h021, v); chk("R8 counts with gating clear", v, 17);
    cpuHalted = 1'b0;

    // R9 count write priority, R2 unmapped write ignored
    wr(12'h023, 4);
    wr(12'h022, 1);
    wr(12'h021, 0);
    wr(12'h024, 32'hDEADBEEF);
    rd(12'h023, v); chk("R2 limit untouched", v, 4);
    waitClk(3);
    rd(12'h021, v); chk("R4 reaches limit", v, 4);
    wr(12'h021, 100);
    rd(12'h021, v); chk("R9 write beats increment", v, 100);
    chk("R9 no match on write edge", {31'd0, timerIrq[0]}, 0);
    waitClk(1);
    rd(12'h021, v); chk("R9 counts from written value", v, 101);
    chk("R9 still no irq", {31'd0, timerIrq[0]}, 0);

    // R10 timer 1 free-running wrap
    wr(12'h022, 0);
    wr(12'h102, 32'hFFFFFFFF);
    wr(12'h101, 0);
    wr(12'h100, 32'hFFFFFFFD);
    waitClk(2);
    rd(12'h100, v); chk("R10 at all ones", v, 32'hFFFFFFFF);
    waitClk(1);
    rd(12'h100, v); chk("R10 wrap to zero", v, 0);
    waitClk(1);
    rd(12'h100, v); chk("R10 after wrap", v, 1);
    chk("R10 no irq", {31'd0, timerIrq[1]}, 0);

    // R11 independence
    wr(12'h102, 2);
    wr(12'h101, 1);
    wr(12'h100, 0);
    waitClk(3);
    chk("R11 t1 irq", {31'd0, timerIrq[1]}, 1);
    chk("R11 t0 irq quiet", {31'd0, timerIrq[0]}, 0);
    rd(12'h022, v); chk("R11 t0 ctrl unchanged", v, 0);
    rd(12'h023, v); chk("R11 t0 limit unchanged", v, 4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule